// File: doc/BRIEF.md
# Contact Wetting Pulse Controller

This block drives the enables of the wetting-current sinks in an eight-input switch monitor. Wetting current is a deliberately large current pushed through a closed contact to clean it. The block takes the debounced state of each switch and a valid-change strobe from the debounce stage. It also takes the command bits that decide how and when current may flow: a global enable, timed-pulse mode, and a bit that selects direct-input mode for inputs 0 and 1. A scan-mode flag with its polling strobe and an over-temperature flag complete the inputs. It produces one sink enable per input, plus the data and output-enable lines of the two direct-drive outputs.

In continuous mode, every eligible closed switch carries current for as long as it stays closed. In timed mode, a single shared counter opens a window of `WIN_CYC` clock cycles, about 20 ms, each time a valid change is seen. During that window every closed switch carries current, whichever one changed. A new change inside the window reloads the counter, so the pulse lasts longer. In scan mode, current flows only while the polling strobe is high. An over-temperature warning, or a cleared global enable, removes all current in the same cycle.

When the direct-input bit is clear and scan mode is off, inputs 0 and 1 bypass monitoring. Their levels appear on the direct outputs, and their sinks stay off.

Top module: `wet_pulse_ctrl`

## Requirements
- R1: While `rst_ni` is low, and in the first clock cycle after it is released, every bit of `sink_en_o` is 0.
- R2: With `wet_en_i` = 0, every bit of `sink_en_o` is 0 in the same cycle, and any strobe on `chg_vld_i` is ignored. Clearing `wet_en_i` also empties the window counter, so re-enabling timed mode without a new strobe gives no current.
- R3: Continuous mode (`wet_en_i`=1, `timed_i`=0, `scan_i`=0, `ot_i`=0): `sink_en_o[i]` = `sw_closed_i[i]` for every eligible input.
- R4: `sink_en_o[i]` is never 1 while `sw_closed_i[i]` is 0.
- R5: Timed mode: a `chg_vld_i` strobe sampled at a rising edge enables every eligible closed switch for exactly `WIN_CYC` cycles, counted from that edge. After the window, the sinks are off.
- R6: A strobe sampled while a window is open, including in its last cycle, restarts the window. Current then ends `WIN_CYC` cycles after the latest strobe.
- R7: Scan mode (`scan_i`=1, `wet_en_i`=1, `ot_i`=0): `sink_en_o[i]` = `sw_closed_i[i]` & `poll_i` for all eight inputs, whatever the value of `timed_i`.
- R8: Direct mode (`mon_low_i`=0, `scan_i`=0): `sink_en_o[1:0]` = 0, `dir_oe_o` = 2'b11 and `dir_o` = `sw_closed_i[1:0]`.
- R9: When `mon_low_i`=1 or `scan_i`=1, `dir_oe_o` = 2'b00 and `dir_o` = 2'b00, and inputs 0 and 1 are eligible for current.
- R10: While `ot_i`=1, every bit of `sink_en_o` is 0. Once `ot_i` returns to 0, current resumes in the same cycle if the active mode still grants it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_closed_i | input | 8 | Debounced switch states, 1 = closed |
| chg_vld_i | input | 1 | Valid-change strobe from the debounce stage |
| wet_en_i | input | 1 | Global wetting enable |
| timed_i | input | 1 | Timed-pulse mode select |
| mon_low_i | input | 1 | 1 = inputs 0/1 monitored, 0 = direct pass-through |
| scan_i | input | 1 | Scan mode active |
| poll_i | input | 1 | Polling-pulse strobe in scan mode |
| ot_i | input | 1 | Over-temperature warning, hysteresis applied upstream |
| sink_en_o | output | 8 | Per-input wetting sink enable |
| dir_o | output | 2 | Direct-drive output data for inputs 0 and 1 |
| dir_oe_o | output | 2 | Direct-drive output enable, 0 = tri-state |

## Verification
The window reload and the window expiry can fall in the same cycle. The bench provokes this by sending a strobe exactly when the counter shows its final active cycle. It then judges the result by checking that current continues, with no gap, for a full fresh window. Over-temperature can also arrive in the middle of an open window. The bench asserts it for one cycle and checks that the sinks drop at once and return in the next cycle, while the window keeps counting. A near-exhaustive sweep over all 256 switch patterns, under every combination of enable, direct, scan, poll and over-temperature, judges the combinational gating against values the bench computes on its own.

// File: rtl/wet_pkg.sv
package wet_pkg;
  typedef enum logic [1:0] {
    GATE_OFF   = 2'd0,
    GATE_CONT  = 2'd1,
    GATE_TIMED = 2'd2,
    GATE_POLL  = 2'd3
  } gate_mode_e;
endpackage

// File: rtl/wet_timer.sv
module wet_timer #(
  parameter int unsigned WIN_CYC = 2_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic load_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(WIN_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (load_i)            cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD_VAL) else $error("count above window"); // R5
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> (cnt_q == LOAD_VAL)) else $error("no reload"); // R6
  AST_CLR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !active_o) else $error("clear kept window"); // R2
endmodule

// File: rtl/wet_mode_dec.sv
module wet_mode_dec
  import wet_pkg::*;
(
  input  logic       run_i,
  input  logic       wet_en_i,
  input  logic       timed_i,
  input  logic       scan_i,
  input  logic       ot_i,
  output gate_mode_e mode_o
);
  always_comb begin
    if (!run_i || !wet_en_i || ot_i) mode_o = GATE_OFF;
    else if (scan_i)                 mode_o = GATE_POLL;
    else if (timed_i)                mode_o = GATE_TIMED;
    else                             mode_o = GATE_CONT;
  end
endmodule

// File: rtl/wet_sink_gate.sv
module wet_sink_gate
  import wet_pkg::*;
#(
  parameter int unsigned N_IN  = 8,
  parameter int unsigned N_DIR = 2
) (
  input  gate_mode_e        mode_i,
  input  logic              active_i,
  input  logic              poll_i,
  input  logic              dir_sel_i,
  input  logic [N_IN-1:0]   sw_closed_i,
  output logic [N_IN-1:0]   sink_en_o
);
  logic grant;

  always_comb begin
    unique case (mode_i)
      GATE_CONT:  grant = 1'b1;
      GATE_TIMED: grant = active_i;
      GATE_POLL:  grant = poll_i;
      default:    grant = 1'b0;
    endcase
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_sink
    if (i < N_DIR) begin : g_dir
      assign sink_en_o[i] = grant & sw_closed_i[i] & ~dir_sel_i;
    end else begin : g_mon
      assign sink_en_o[i] = grant & sw_closed_i[i];
    end
  end
endmodule

// File: rtl/wet_direct.sv
module wet_direct #(
  parameter int unsigned N_DIR = 2
) (
  input  logic [N_DIR-1:0] sw_i,
  input  logic             mon_low_i,
  input  logic             scan_i,
  output logic             dir_sel_o,
  output logic [N_DIR-1:0] dir_o,
  output logic [N_DIR-1:0] dir_oe_o
);
  assign dir_sel_o = ~mon_low_i & ~scan_i;
  assign dir_oe_o  = {N_DIR{dir_sel_o}};
  assign dir_o     = sw_i & {N_DIR{dir_sel_o}};
endmodule

// File: rtl/wet_pulse_ctrl.sv
module wet_pulse_ctrl
  import wet_pkg::*;
#(
  parameter int unsigned N_IN    = 8,
  parameter int unsigned WIN_CYC = 2_000_000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_IN-1:0] sw_closed_i,
  input  logic            chg_vld_i,
  input  logic            wet_en_i,
  input  logic            timed_i,
  input  logic            mon_low_i,
  input  logic            scan_i,
  input  logic            poll_i,
  input  logic            ot_i,
  output logic [N_IN-1:0] sink_en_o,
  output logic [1:0]      dir_o,
  output logic [1:0]      dir_oe_o
);
  localparam int unsigned N_DIR = 2;

  logic       run_q;
  logic       active;
  logic       dir_sel;
  gate_mode_e mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  wet_timer #(.WIN_CYC(WIN_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (~wet_en_i),
    .load_i   (wet_en_i & chg_vld_i),
    .active_o (active)
  );

  wet_mode_dec u_dec (
    .run_i    (run_q),
    .wet_en_i (wet_en_i),
    .timed_i  (timed_i),
    .scan_i   (scan_i),
    .ot_i     (ot_i),
    .mode_o   (mode)
  );

  wet_direct #(.N_DIR(N_DIR)) u_dir (
    .sw_i      (sw_closed_i[N_DIR-1:0]),
    .mon_low_i (mon_low_i),
    .scan_i    (scan_i),
    .dir_sel_o (dir_sel),
    .dir_o     (dir_o),
    .dir_oe_o  (dir_oe_o)
  );

  wet_sink_gate #(.N_IN(N_IN), .N_DIR(N_DIR)) u_gate (
    .mode_i      (mode),
    .active_i    (active),
    .poll_i      (poll_i),
    .dir_sel_i   (dir_sel),
    .sw_closed_i (sw_closed_i),
    .sink_en_o   (sink_en_o)
  );

  AST_OPEN_NO_CUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sink_en_o & ~sw_closed_i) == '0) else $error("current on open switch"); // R4
  AST_OT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_i |-> (sink_en_o == '0)) else $error("current during overtemp"); // R10
  AST_DIS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wet_en_i |-> (sink_en_o == '0)) else $error("current while disabled"); // R2
  AST_DIR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_oe_o != 2'b00) |-> (sink_en_o[1:0] == 2'b00)) else $error("sink on direct input"); // R8
  AST_SCAN_TRI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_i |-> (dir_oe_o == 2'b00)) else $error("direct drive in scan"); // R9
  AST_POLL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_i && !poll_i) |-> (sink_en_o == '0)) else $error("current outside poll"); // R7
endmodule

// File: tb/wet_pulse_ctrl_bench.sv
module wet_pulse_ctrl_bench;
  localparam int W = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sw = '0;
  logic       chg = 1'b0, wen = 1'b0, timed = 1'b0, mon = 1'b1;
  logic       scan = 1'b0, poll = 1'b0, ot = 1'b0;
  logic [7:0] sink;
  logic [1:0] dout, doe;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  wet_pulse_ctrl #(.N_IN(8), .WIN_CYC(W)) u_wet_pulse_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sw_closed_i(sw), .chg_vld_i(chg),
    .wet_en_i(wen), .timed_i(timed), .mon_low_i(mon), .scan_i(scan),
    .poll_i(poll), .ot_i(ot), .sink_en_o(sink), .dir_o(dout), .dir_oe_o(doe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk); chg = 1'b1;
    @(posedge clk); #1 chg = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset forces sinks off even with current requested
    wen = 1'b1; sw = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 in reset", sink, 8'h00);
    rst_n = 1'b1;
    #1 chk("R1 first cycle", sink, 8'h00);
    @(negedge clk);
    chk("R3 after reset", sink, 8'hFF);

    // sweep of the combinational gating, timer idle
    wen = 1'b0; @(posedge clk); // empties window
    for (int c = 0; c < 32; c++) begin
      for (int s = 0; s < 256; s++) begin
        logic [7:0] elig, exp_s;
        logic       gate, dsel;
        string      tg;
        @(negedge clk);
        {wen, mon, scan, poll, ot} = c[4:0];
        timed = 1'b0;
        sw = s[7:0];
        #1;
        dsel  = !mon && !scan;
        elig  = dsel ? 8'hFC : 8'hFF;
        gate  = wen && !ot && (scan ? poll : 1'b1);
        exp_s = sw & elig & {8{gate}};
        if (ot && wen)     tg = "R10 ot";
        else if (!wen)     tg = "R2 disabled";
        else if (scan)     tg = "R7 scan";
        else if (dsel)     tg = "R8 direct";
        else               tg = "R3 continuous";
        chk(tg, sink, exp_s);
        chk(dsel ? "R8 dir out" : "R9 tristate", {dout, doe},
            dsel ? {sw[1:0], 2'b11} : 4'b0000);
      end
    end

    // R4: open switches receive nothing
    @(negedge clk);
    wen = 1; mon = 1; scan = 0; poll = 0; ot = 0; timed = 0; sw = 8'hA5;
    #1 chk("R4 open excluded", sink, 8'hA5);

    // R7: scan ignores timed mode
    @(negedge clk); scan = 1; timed = 1; poll = 1; sw = 8'h81;
    #1 chk("R7 scan timed", sink, 8'h81);
    @(negedge clk); scan = 0;

    // R5: single window
    @(negedge clk); timed = 1; sw = 8'h3C;
    #1 chk("R5 idle", sink, 8'h00);
    strobe();
    for (int k = 0; k < W; k++) begin
      @(negedge clk); chk("R5 window on", sink, 8'h3C);
    end
    @(negedge clk); chk("R5 window off", sink, 8'h00);

    // R6: restart mid-window
    strobe();
    repeat (3) @(negedge clk);
    strobe();
    for (int k = 0; k < W; k++) begin
      @(negedge clk); chk("R6 restart on", sink, 8'h3C);
    end
    @(negedge clk); chk("R6 restart off", sink, 8'h00);

    // R6: strobe in last active cycle
    strobe();
    for (int k = 0; k < W; k++) begin
      @(negedge clk); chk("R6 last on", sink, 8'h3C);
    end
    chg = 1'b1;
    @(posedge clk); #1 chg = 1'b0;
    for (int k = 0; k < W; k++) begin
      @(negedge clk); chk("R6 reload on", sink, 8'h3C);
    end
    @(negedge clk); chk("R6 reload off", sink, 8'h00);

    // R10: overtemp mid-window, resume
    strobe();
    @(negedge clk); ot = 1;
    #1 chk("R10 ot off", sink, 8'h00);
    @(negedge clk); ot = 0;
    #1 chk("R10 resume", sink, 8'h3C);

    // R2: disable clears window
    strobe();
    @(negedge clk); wen = 0;
    #1 chk("R2 drop", sink, 8'h00);
    @(negedge clk); wen = 1;
    #1 chk("R2 window cleared", sink, 8'h00);
    @(negedge clk); wen = 0; chg = 1;
    @(posedge clk); #1 chg = 0;
    @(negedge clk); wen = 1;
    #1 chk("R2 strobe ignored", sink, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule